// File: doc/BRIEF.md
# Mixed-Length Instruction Fetch Window

This block is the fetch stage of a core whose instruction set mixes 16-bit and 32-bit encodings. It owns the program counter, which counts in halfwords, and presents it each cycle as the address of a combinational instruction-memory read port. The halfword that comes back is byte-swapped and shifted into a two-halfword window. The decoder reads the upper half of that window. When the upper half is the first halfword of a 32-bit instruction, the decoder uses the whole window.

The top bit of the window gives the instruction length. When it marks a 32-bit instruction, the block squashes the trailing halfword, so that the second half of the long instruction is never decoded on its own. The execute stage can redirect fetch with a relative branch or an absolute jump. After a redirect the window is refilled with no-operation words while the new stream arrives.

Each clock the control logic picks one of four named actions: ACT_SHIFT (advance normally), ACT_SQUASH (advance, but put a NOP in the upper half), ACT_BRANCH (relative redirect) and ACT_JUMP (absolute redirect). The decision depends only on the current request and on the length bit, so this choice is the only state transition in the block. The program-counter register and the window register both follow the chosen action.

Top module: `hw_fetch_window`

## Requirements
- R1: While reset is high, at the next clock edge the read address becomes 0 and the window becomes 0x0001_0001 (both halves NOP). Reset takes priority over any redirect request.
- R2: Without a redirect, each clock edge moves the old lower half into the upper half. The newly read halfword then becomes the lower half.
- R3: A read halfword enters the window byte-swapped. Memory bits 15:8 go to window bits 7:0, and memory bits 7:0 go to window bits 15:8.
- R4: Window bit 31 set means the window holds a 32-bit instruction. At the next edge without a redirect, the upper half becomes the NOP 0x0001 instead of the old lower half, and the new halfword still enters the lower half.
- R5: Without a redirect, the program counter increments by one on every edge. The read address always equals the program counter.
- R6: A request code of 1 is a relative branch. It sets the counter to its current value plus the sign-extended offset minus 1, and loads both window halves with 0x0001.
- R7: A request code of 2 is an absolute jump. When the target differs from the counter, the counter is loaded with the target and both window halves are loaded with 0x0001.
- R8: An absolute jump whose target equals the current counter behaves as normal fetching (R2, R4, R5). Request codes 0 and 3 cause no redirect.
- R9: When a redirect and a 32-bit squash fall on the same edge, the redirect wins: the counter follows R6 or R7, and both halves become 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_rdata | input | 16 | Halfword returned by the instruction memory for imem_addr |
| redir_req | input | 2 | Redirect request: 0 none, 1 relative, 2 absolute, 3 none |
| redir_offset | input | OFF_W (8) | Signed halfword offset for a relative branch |
| redir_target | input | PC_W (16) | Halfword address for an absolute jump |
| imem_addr | output | PC_W (16) | Read address, equal to the program counter |
| fetch_win | output | 32 | Decode window: upper half older, lower half newest |

## Verification
The bench goes after five corner cases:

- A 32-bit instruction in the upper half. A design that ignored the length bit would pass the trailing halfword on to decode as a stray instruction.
- A branch or jump that arrives in the same cycle as a squash. If the squash won, the new upper half would be the stale lower half and the counter would not move to the target.
- An absolute jump to the counter's current value. This must fall back to normal fetching, so a design that refilled with NOPs anyway would lose a halfword.
- A relative branch with a negative offset and one with an offset of zero. A design that dropped the minus-one correction, or that zero-extended the offset, would land on the wrong address.
- Request code 3. A design that decoded it as a redirect would jump.

The bench also asserts reset while a jump is requested, and checks that the reset state wins.

// File: rtl/hw_fetch_pkg.sv
package hw_fetch_pkg;

    localparam logic [15:0] NOP_HALF = 16'h0001;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_REL  = 2'd1,
        REQ_ABS  = 2'd2,
        REQ_RSVD = 2'd3
    } req_e;

    typedef enum logic [1:0] {
        ACT_SHIFT  = 2'd0,
        ACT_SQUASH = 2'd1,
        ACT_BRANCH = 2'd2,
        ACT_JUMP   = 2'd3
    } act_e;

    function automatic logic [15:0] swap_bytes(input logic [15:0] h);
        return {h[7:0], h[15:8]};
    endfunction

endpackage

// File: rtl/hw_fetch_ctrl.sv
module hw_fetch_ctrl
    import hw_fetch_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      req_i,
    input  logic            long_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] target_i,
    output act_e            act_o
);

    act_e stream_act;

    always_comb begin
        stream_act = long_i ? ACT_SQUASH : ACT_SHIFT;
    end

    always_comb begin
        unique case (req_e'(req_i))
            REQ_REL:  act_o = ACT_BRANCH;
            REQ_ABS:  act_o = (pc_i != target_i) ? ACT_JUMP : stream_act;
            REQ_NONE: act_o = stream_act;
            REQ_RSVD: act_o = stream_act;
            default:  act_o = stream_act;
        endcase
    end

    // R9: a redirect outranks the squash of a 32-bit trailing halfword
    a_r9_redirect_wins: assert property (@(posedge clk) disable iff (rst)
        (long_i && req_i == 2'd1) |-> (act_o == ACT_BRANCH));

    // R8: unused request codes never redirect
    a_r8_no_redirect: assert property (@(posedge clk) disable iff (rst)
        (req_i == 2'd0 || req_i == 2'd3) |-> (act_o == ACT_SHIFT || act_o == ACT_SQUASH));

endmodule

// File: rtl/hw_fetch_pc.sv
module hw_fetch_pc
    import hw_fetch_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  act_e             act_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic [PC_W-1:0]  target_i,
    output logic [PC_W-1:0]  pc_o
);

    localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] off_ext;

    always_comb begin
        off_ext = PC_W'($signed(offset_i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            unique case (act_i)
                ACT_SHIFT:  pc_q <= pc_q + PC_ONE;
                ACT_SQUASH: pc_q <= pc_q + PC_ONE;
                ACT_BRANCH: pc_q <= pc_q + off_ext - PC_ONE;
                ACT_JUMP:   pc_q <= target_i;
                default:    pc_q <= pc_q + PC_ONE;
            endcase
        end
    end

    assign pc_o = pc_q;

    // R5: normal fetching steps by one halfword
    a_r5_pc_step: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_SHIFT || act_i == ACT_SQUASH) |=> (pc_q == $past(pc_q) + PC_ONE));

    // R7: an absolute jump lands on the requested target
    a_r7_jump_load: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_JUMP) |=> (pc_q == $past(target_i)));

endmodule

// File: rtl/hw_fetch_shift.sv
module hw_fetch_shift
    import hw_fetch_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  act_e        act_i,
    input  logic [15:0] rdata_i,
    output logic [31:0] win_o
);

    logic [15:0] upper_q;
    logic [15:0] lower_q;
    logic [15:0] incoming;

    always_comb begin
        incoming = swap_bytes(rdata_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= NOP_HALF;
            lower_q <= NOP_HALF;
        end else begin
            unique case (act_i)
                ACT_SHIFT: begin
                    upper_q <= lower_q;
                    lower_q <= incoming;
                end
                ACT_SQUASH: begin
                    upper_q <= NOP_HALF;
                    lower_q <= incoming;
                end
                ACT_BRANCH, ACT_JUMP: begin
                    upper_q <= NOP_HALF;
                    lower_q <= NOP_HALF;
                end
                default: begin
                    upper_q <= lower_q;
                    lower_q <= incoming;
                end
            endcase
        end
    end

    assign win_o = {upper_q, lower_q};

    // R2: the lower half advances into the upper half
    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_SHIFT) |=> (win_o[31:16] == $past(win_o[15:0])));

    // R3: new halfword enters with its bytes exchanged
    a_r3_swap: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_SHIFT || act_i == ACT_SQUASH) |=>
        (win_o[7:0] == $past(rdata_i[15:8]) && win_o[15:8] == $past(rdata_i[7:0])));

    // R4: trailing half of a long instruction is replaced by a NOP
    a_r4_squash_nop: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_SQUASH) |=> (win_o[31:16] == 16'h0001));

    // R6: a redirect refills the whole window with NOPs
    a_r6_refill: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_BRANCH || act_i == ACT_JUMP) |=> (win_o == 32'h0001_0001));

endmodule

// File: rtl/hw_fetch_window.sv
module hw_fetch_window
    import hw_fetch_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      imem_rdata,
    input  logic [1:0]       redir_req,
    input  logic [OFF_W-1:0] redir_offset,
    input  logic [PC_W-1:0]  redir_target,
    output logic [PC_W-1:0]  imem_addr,
    output logic [31:0]      fetch_win
);

    act_e            act;
    logic [PC_W-1:0] pc;
    logic [31:0]     win;

    hw_fetch_ctrl #(.PC_W(PC_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req_i    (redir_req),
        .long_i   (win[31]),
        .pc_i     (pc),
        .target_i (redir_target),
        .act_o    (act)
    );

    hw_fetch_pc #(.PC_W(PC_W), .OFF_W(OFF_W)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .act_i    (act),
        .offset_i (redir_offset),
        .target_i (redir_target),
        .pc_o     (pc)
    );

    hw_fetch_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .act_i   (act),
        .rdata_i (imem_rdata),
        .win_o   (win)
    );

    assign imem_addr = pc;
    assign fetch_win = win;

    // R1: the reset state is address zero and an all-NOP window
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (imem_addr == '0 && fetch_win == 32'h0001_0001));

endmodule

// File: tb/hw_fetch_window_tb.sv
module hw_fetch_window_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] imem_rdata = 16'h0000;
    logic [1:0]  redir_req = 2'd0;
    logic [7:0]  redir_offset = 8'h00;
    logic [15:0] redir_target = 16'h0000;
    logic [15:0] imem_addr;
    logic [31:0] fetch_win;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    hw_fetch_window u_dut (
        .clk          (clk),
        .rst          (rst),
        .imem_rdata   (imem_rdata),
        .redir_req    (redir_req),
        .redir_offset (redir_offset),
        .redir_target (redir_target),
        .imem_addr    (imem_addr),
        .fetch_win    (fetch_win)
    );

    // fields: rdata, req, offset, target, expected addr, expected window
    localparam int NV = 22;
    localparam logic [89:0] VEC [NV] = '{
        {16'h3412, 2'd0, 8'h00, 16'h0000, 16'h0001, 32'h0001_1234},
        {16'h7856, 2'd0, 8'h00, 16'h0000, 16'h0002, 32'h1234_5678},
        {16'h00A1, 2'd0, 8'h00, 16'h0000, 16'h0003, 32'h5678_A100},
        {16'hCDAB, 2'd0, 8'h00, 16'h0000, 16'h0004, 32'hA100_ABCD},
        {16'h2211, 2'd0, 8'h00, 16'h0000, 16'h0005, 32'h0001_1122},
        {16'h4433, 2'd0, 8'h00, 16'h0000, 16'h0006, 32'h1122_3344},
        {16'h9999, 2'd1, 8'h04, 16'h0000, 16'h0009, 32'h0001_0001},
        {16'h6655, 2'd0, 8'h00, 16'h0000, 16'h000A, 32'h0001_5566},
        {16'h0080, 2'd0, 8'h00, 16'h0000, 16'h000B, 32'h5566_8000},
        {16'h7777, 2'd0, 8'h00, 16'h0000, 16'h000C, 32'h8000_7777},
        {16'h1111, 2'd1, 8'hFD, 16'h0000, 16'h0008, 32'h0001_0001},
        {16'hBBAA, 2'd0, 8'h00, 16'h0000, 16'h0009, 32'h0001_AABB},
        {16'h2222, 2'd2, 8'h00, 16'h0040, 16'h0040, 32'h0001_0001},
        {16'h0180, 2'd0, 8'h00, 16'h0000, 16'h0041, 32'h0001_8001},
        {16'h0280, 2'd0, 8'h00, 16'h0000, 16'h0042, 32'h8001_8002},
        {16'h3412, 2'd2, 8'h00, 16'h0042, 16'h0043, 32'h0001_1234},
        {16'h0000, 2'd3, 8'h00, 16'h0000, 16'h0044, 32'h1234_0000},
        {16'h3333, 2'd2, 8'h00, 16'h0010, 16'h0010, 32'h0001_0001},
        {16'h4444, 2'd1, 8'h00, 16'h0000, 16'h000F, 32'h0001_0001},
        {16'h5AA5, 2'd0, 8'h00, 16'h0000, 16'h0010, 32'h0001_A55A},
        {16'h0000, 2'd0, 8'h00, 16'h0000, 16'h0011, 32'hA55A_0000},
        {16'h6666, 2'd2, 8'h00, 16'h0005, 16'h0005, 32'h0001_0001}
    };

    // requirement covered by each vector step
    localparam string TAGS [NV] = '{
        "R3", "R2", "R5", "R2", "R4", "R4", "R6", "R6", "R3", "R2", "R9",
        "R2", "R7", "R7", "R5", "R8", "R8", "R7", "R6", "R3", "R5", "R9"
    };

    task automatic check_addr(input string tag, input logic [15:0] exp);
        checks++;
        if (imem_addr !== exp) begin
            errors++;
            $display("FAIL %s addr actual=%h expected=%h", tag, imem_addr, exp);
        end
    endtask

    task automatic check_win(input string tag, input logic [31:0] exp);
        checks++;
        if (fetch_win !== exp) begin
            errors++;
            $display("FAIL %s window actual=%h expected=%h", tag, fetch_win, exp);
        end
    endtask

    task automatic apply(input logic [89:0] v);
        imem_rdata   = v[89:74];
        redir_req    = v[73:72];
        redir_offset = v[71:64];
        redir_target = v[63:48];
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_addr("R1", 16'h0000);
        check_win("R1", 32'h0001_0001);
        rst = 1'b0;
        apply(VEC[0]);
        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            @(negedge clk);
            check_addr(TAGS[i], VEC[i][47:32]);
            check_win(TAGS[i], VEC[i][31:0]);
            if (i + 1 < NV) apply(VEC[i + 1]);
        end
        // R1: reset dominates a simultaneous absolute jump request
        apply({16'h1234, 2'd2, 8'h00, 16'h0030, 16'h0000, 32'h0});
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_addr("R1", 16'h0000);
        check_win("R1", 32'h0001_0001);
        // R5: fetching restarts from zero after the reset
        rst = 1'b0;
        apply({16'hEFBE, 2'd0, 8'h00, 16'h0000, 16'h0000, 32'h0});
        @(posedge clk);
        @(negedge clk);
        check_addr("R5", 16'h0001);
        check_win("R3", 32'h0001_BEEF);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule